// File: doc/BRIEF.md
# Multi-Bank Synchronous Clock Divider

This block turns one fast source clock into a family of related slower clocks. It models the digital back end of a frequency synthesiser: a fast clock stands in for the oscillator, and the block derives three clock banks, a fourth bank that either mirrors the third or carries a synchronisation pulse, and a coarse feedback clock. All dividers advance on one shared prescaled tick. A single master reset releases them together, so every output starts in phase.

The source clock is normally the fast clock. In bypass mode a reference clock takes its place. The reference is either a differential pair or a single-ended input, picked by a select pin. All division is done with clock enables on the source clock and holds no state that decays, so the logic works statically down to a stopped source. Divide-select changes are taken at a divider's period boundary, so no output ever shows a runt pulse.

The outputs are clocks, not a data stream. There is no valid/ready handshake and no back-pressure. Every control input is a plain level.

Top module: `bank_clk_div`

## Requirements
- R1: While `mr` is high, every output is low, asynchronously to any clock. A reset pulse one source-clock cycle long is enough to return the block to its post-reset state.
- R2: `pre_sel`=0 divides the source clock by 2 and `pre_sel`=1 divides it by 4. The result is the prescaled tick. Outputs change only on source edges where a tick occurs.
- R3: `q_a`, `q_b` and `q_c` each divide the prescaled tick by 2, 4, 6 or 8 for select codes 2'b00, 2'b01, 2'b10 and 2'b11. Each output is high for exactly half its period.
- R4: `q_fb` divides the prescaled tick by 16, 24 or 32 for `sel_fb` codes 0, 1 and 2. Any other code gives 32. The duty cycle is 50%.
- R5: On the first source edge after `mr` falls, `q_a`, `q_b`, `q_c` and `q_fb` all rise together.
- R6: A new divide-select value is taken only when that output next rises. The period in progress completes with the old ratio.
- R7: With `sync_sel`=1, both bits of `q_d` equal `q_c`.
- R8: With `sync_sel`=0, both bits of `q_d` carry a sync pulse. The pulse is high for one prescaled cycle, the one just before a tick on which the fastest and the slowest of banks a, b and c both rise. It is low before the first tick after reset.
- R9: `ref_sel`=0 picks the differential pair, which reads high when `ref_p`=1 and `ref_n`=0. `ref_sel`=1 picks `ref_se`. This choice has an effect only in bypass.
- R10: With `bypass`=1, the selected reference is the source clock. If that reference stops, every output holds its level, and division resumes correctly when it restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast source clock (oscillator stand-in) |
| ref_p | input | 1 | Differential reference, true leg |
| ref_n | input | 1 | Differential reference, complement leg |
| ref_se | input | 1 | Single-ended reference |
| ref_sel | input | 1 | 0: differential pair, 1: single-ended |
| bypass | input | 1 | 1: reference clock replaces clk_vco |
| mr | input | 1 | Asynchronous master reset, active high |
| pre_sel | input | 1 | Prescale: 0 divides by 2, 1 divides by 4 |
| sel_a | input | SEL_W | Bank a ratio select |
| sel_b | input | SEL_W | Bank b ratio select |
| sel_c | input | SEL_W | Bank c ratio select |
| sel_fb | input | FB_SEL_W | Feedback ratio select |
| sync_sel | input | 1 | 0: q_d carries sync pulse, 1: q_d mirrors q_c |
| q_a | output | 1 | Bank a clock |
| q_b | output | 1 | Bank b clock |
| q_c | output | 1 | Bank c clock |
| q_d | output | 2 | Bank d pair: sync pulse or copy of q_c |
| q_fb | output | 1 | Feedback clock |

## Verification
The bench builds the block with its default parameters: 2-bit bank selects, a 3-bit feedback select and a 5-bit half-period counter. These widths reach all four bank ratios, all eight feedback codes (including the five that fall back to 32) and the longest half period of 16 ticks. Random selects under both prescale settings reach every pairing of fastest and slowest bank, including ties, for the sync-pulse check. Bypass runs with two references of different periods, plus a stopped reference, reach the static behaviour and the reference selection.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned BANK_SEL_W = 2;
  localparam int unsigned FB_SEL_W   = 3;
  localparam int unsigned HALF_W     = 5;
  localparam int unsigned PRE_W      = 2;
  localparam int unsigned N_BANKS    = 3;

  // half period in ticks for a bank select code: 2,4,6,8 -> 1,2,3,4
  function automatic int unsigned bank_half(int unsigned code);
    return code + 1;
  endfunction

  // half period for the feedback select: 16,24,32 -> 8,12,16
  function automatic int unsigned fb_half(int unsigned code);
    case (code)
      0:       return 8;
      1:       return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/bcd_prescale.sv
module bcd_prescale #(
  parameter int unsigned W = 2
) (
  input  logic clk,
  input  logic mr,
  input  logic div4,
  output logic tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk or posedge mr) begin
    if (mr)        cnt <= '0;
    else if (tick) cnt <= div4 ? W'(3) : W'(1);
    else           cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/bcd_div.sv
module bcd_div #(
  parameter int unsigned HW = 5
) (
  input  logic          clk,
  input  logic          mr,
  input  logic          tick,
  input  logic [HW-1:0] half_sel,
  output logic          q,
  output logic          rise_next,
  output logic [HW-1:0] half_cur
);
  logic [HW-1:0] cnt;
  logic [HW-1:0] half_q;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      cnt    <= '0;
      q      <= 1'b0;
      half_q <= '0;
    end else if (tick) begin
      if (cnt == '0) begin
        q <= ~q;
        if (!q) begin
          // period boundary: the new ratio is taken only here
          half_q <= half_sel;
          cnt    <= half_sel - 1'b1;
        end else begin
          cnt <= half_q - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign rise_next = (cnt == '0) && !q;
  assign half_cur  = half_q;
endmodule

// File: rtl/bcd_sync_pick.sv
module bcd_sync_pick #(
  parameter int unsigned NB = 3,
  parameter int unsigned HW = 5
) (
  input  logic [NB-1:0][HW-1:0] half,
  input  logic [NB-1:0]         rise_next,
  input  logic                  started,
  output logic                  sync
);
  int unsigned lo, hi;

  always_comb begin
    lo = 0;
    hi = 0;
    for (int unsigned i = 1; i < NB; i++) begin
      if (half[i] < half[lo]) lo = i;
      if (half[i] > half[hi]) hi = i;
    end
    sync = started && rise_next[lo] && rise_next[hi];
  end
endmodule

// File: rtl/bank_clk_div.sv
module bank_clk_div
  import bcd_pkg::*;
#(
  parameter int unsigned SEL_W    = BANK_SEL_W,
  parameter int unsigned FB_SEL_W = bcd_pkg::FB_SEL_W,
  parameter int unsigned HALF_W   = bcd_pkg::HALF_W
) (
  input  logic                clk_vco,
  input  logic                ref_p,
  input  logic                ref_n,
  input  logic                ref_se,
  input  logic                ref_sel,
  input  logic                bypass,
  input  logic                mr,
  input  logic                pre_sel,
  input  logic [SEL_W-1:0]    sel_a,
  input  logic [SEL_W-1:0]    sel_b,
  input  logic [SEL_W-1:0]    sel_c,
  input  logic [FB_SEL_W-1:0] sel_fb,
  input  logic                sync_sel,
  output logic                q_a,
  output logic                q_b,
  output logic                q_c,
  output logic [1:0]          q_d,
  output logic                q_fb
);
  localparam int unsigned NB = N_BANKS;

  logic ref_clk, src_clk, tick, started, sync_w, fb_rise;
  logic [NB-1:0][SEL_W-1:0]  bsel;
  logic [NB-1:0][HALF_W-1:0] bhalf;
  logic [NB-1:0]             bq, brise;
  logic [HALF_W-1:0]         fb_cur;

  assign ref_clk = ref_sel ? ref_se : (ref_p & ~ref_n);
  assign src_clk = bypass ? ref_clk : clk_vco;

  bcd_prescale #(.W(PRE_W)) u_pre (
    .clk(src_clk), .mr(mr), .div4(pre_sel), .tick(tick)
  );

  assign bsel = {sel_c, sel_b, sel_a};

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bcd_div #(.HW(HALF_W)) u_div (
      .clk(src_clk), .mr(mr), .tick(tick),
      .half_sel(HALF_W'(bank_half(int'(bsel[g])))),
      .q(bq[g]), .rise_next(brise[g]), .half_cur(bhalf[g])
    );
  end

  bcd_div #(.HW(HALF_W)) u_fb (
    .clk(src_clk), .mr(mr), .tick(tick),
    .half_sel(HALF_W'(fb_half(int'(sel_fb)))),
    .q(q_fb), .rise_next(fb_rise), .half_cur(fb_cur)
  );

  always_ff @(posedge src_clk or posedge mr) begin
    if (mr)        started <= 1'b0;
    else if (tick) started <= 1'b1;
  end

  bcd_sync_pick #(.NB(NB), .HW(HALF_W)) u_sync (
    .half(bhalf), .rise_next(brise), .started(started), .sync(sync_w)
  );

  assign q_a = bq[0];
  assign q_b = bq[1];
  assign q_c = bq[2];
  assign q_d = sync_sel ? {2{q_c}} : {2{sync_w}};
endmodule

// File: rtl/bank_clk_div_chk.sv
module bank_clk_div_chk (
  input logic       src_clk,
  input logic       mr,
  input logic       tick,
  input logic       started,
  input logic       sync_w,
  input logic       sync_sel,
  input logic       q_a,
  input logic       q_b,
  input logic       q_c,
  input logic [1:0] q_d,
  input logic       q_fb
);
  always @(negedge src_clk) begin
    if (mr) begin
      AST_RESET_CLEARS: assert ({q_a, q_b, q_c, q_d, q_fb} == 6'b0); // R1
    end
  end

  AST_HOLD_OFF_TICK: assert property (@(posedge src_clk) disable iff (mr)
    !tick |=> $stable({q_a, q_b, q_c, q_fb})); // R2

  AST_FIRST_RISE_ALIGNED: assert property (@(posedge src_clk) disable iff (mr)
    $rose(started) |-> (q_a && q_b && q_c && q_fb)); // R5

  AST_SYNC_ONE_CYCLE: assert property (@(posedge src_clk) disable iff (mr)
    (tick && sync_w) |=> !sync_w); // R8

  AST_SYNC_AT_RISE: assert property (@(posedge src_clk) disable iff (mr)
    (tick && sync_w && !sync_sel) |=> (q_a || q_b || q_c)); // R8
endmodule

bind bank_clk_div bank_clk_div_chk i_chk (
  .src_clk(src_clk), .mr(mr), .tick(tick), .started(started),
  .sync_w(sync_w), .sync_sel(sync_sel), .q_a(q_a), .q_b(q_b),
  .q_c(q_c), .q_d(q_d), .q_fb(q_fb)
);

// File: tb/test_bank_clk_div.sv
module test_bank_clk_div;
  localparam longint T_VCO = 8000;   // 125 MHz, time unit ps
  localparam longint T_DIF = 20000;
  localparam longint T_SE  = 30000;

  logic clk_vco = 1'b0, ref_p = 1'b0, ref_se = 1'b0, ref_run = 1'b1;
  logic ref_n;
  logic ref_sel = 1'b0, bypass = 1'b0, mr = 1'b1, pre_sel = 1'b0, sync_sel = 1'b1;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic q_a, q_b, q_c, q_fb;
  logic [1:0] q_d;
  logic [3:0] qv;
  int errors = 0, checks = 0, cyc = 0;

  assign ref_n = ~ref_p;
  assign qv = {q_fb, q_c, q_b, q_a};

  always #4000 clk_vco = ~clk_vco;
  always begin #10000; if (ref_run) ref_p = ~ref_p; end
  always begin #15000; if (ref_run) ref_se = ~ref_se; end

  bank_clk_div i_bank_clk_div (
    .clk_vco(clk_vco), .ref_p(ref_p), .ref_n(ref_n), .ref_se(ref_se),
    .ref_sel(ref_sel), .bypass(bypass), .mr(mr), .pre_sel(pre_sel),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
    .sync_sel(sync_sel), .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_d(q_d), .q_fb(q_fb)
  );

  function automatic longint b_ratio(int s); return 2 * (s + 1); endfunction
  function automatic longint f_ratio(int s); return s == 0 ? 16 : (s == 1 ? 24 : 32); endfunction
  function automatic bit sync_exp(int e, int p, int rmin, int rmax);
    int m = e / p + 1;
    return (m % rmin == 0) && (m % rmax == 0);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_vco) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic meas(input int idx, output longint per, output longint hi);
    longint t0, t1, t2;
    wait (qv[idx] == 1'b0); wait (qv[idx] == 1'b1); t0 = $time;
    wait (qv[idx] == 1'b0); t1 = $time;
    wait (qv[idx] == 1'b1); t2 = $time;
    per = t2 - t0; hi = t1 - t0;
  endtask

  task automatic start(input bit pre, input int sa, input int sb, input int sc,
                       input int sf, input bit byp, input bit rs, input bit ss);
    mr = 1'b1;
    #20000;
    pre_sel = pre; sel_a = 2'(sa); sel_b = 2'(sb); sel_c = 2'(sc); sel_fb = 3'(sf);
    bypass = byp; ref_sel = rs; sync_sel = ss;
    #20000;
    chk({qv, q_d} == 6'b0, "R1", "outputs low in reset", longint'({qv, q_d}), 0);
    @(negedge clk_vco); #500;
    mr = 1'b0;
  endtask

  initial begin
    longint per, hi, p, ex, tsrc;
    int sa, sb, sc, sf, bad;
    bit pre;
    void'($urandom(32'd20240611));
    #30000;

    // R5 alignment and R7 mirror with directed selects
    start(0, 3, 1, 2, 5, 0, 0, 1);
    @(posedge clk_vco); #1000;
    chk(qv == 4'hf, "R5", "all banks rise on first tick", longint'(qv), 15);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_vco);
      if (q_d != {q_c, q_c}) bad++;
    end
    chk(bad == 0, "R7", "q_d mirrors q_c", bad, 0);

    // R1 short reset pulse in mid run, then R5 re-alignment
    #3300; mr = 1'b1; #100;
    chk({qv, q_d} == 6'b0, "R1", "async clear", longint'({qv, q_d}), 0);
    #8000; mr = 1'b0;
    @(posedge clk_vco); #1000;
    chk(qv == 4'hf, "R1", "aligned after one-cycle reset", longint'(qv), 15);

    // R2 R3 R4 random ratio sweep
    for (int it = 0; it < 8; it++) begin
      pre = 1'($urandom % 2);
      sa = $urandom % 4; sb = $urandom % 4; sc = $urandom % 4; sf = $urandom % 8;
      if (it == 0) begin pre = 0; sa = 0; sf = 7; end
      if (it == 1) begin pre = 1; sb = 3; sf = 1; end
      start(pre, sa, sb, sc, sf, 0, 0, 1);
      p = pre ? 4 : 2;
      meas(0, per, hi); ex = b_ratio(sa) * p * T_VCO;
      chk(per == ex, "R3", "q_a period", per, ex);
      chk(hi == ex / 2, "R3", "q_a high time", hi, ex / 2);
      meas(1, per, hi); ex = b_ratio(sb) * p * T_VCO;
      chk(per == ex, "R2", "q_b period", per, ex);
      chk(hi == ex / 2, "R3", "q_b high time", hi, ex / 2);
      meas(2, per, hi); ex = b_ratio(sc) * p * T_VCO;
      chk(per == ex, "R3", "q_c period", per, ex);
      chk(hi == ex / 2, "R3", "q_c high time", hi, ex / 2);
      meas(3, per, hi); ex = f_ratio(sf) * p * T_VCO;
      chk(per == ex, "R4", "q_fb period", per, ex);
      chk(hi == ex / 2, "R4", "q_fb high time", hi, ex / 2);
    end

    // R6 ratio change mid run: old period completes, then new one
    start(0, 3, 0, 0, 0, 0, 0, 1);
    wait (q_a == 1'b0); wait (q_a == 1'b1);
    per = $time; sel_a = 2'b00;
    wait (q_a == 1'b0); hi = $time - per;
    wait (q_a == 1'b1); per = $time - per;
    chk(per == 8 * 2 * T_VCO, "R6", "period in progress keeps old ratio", per, 8 * 2 * T_VCO);
    chk(hi == 8 * T_VCO, "R6", "no runt high phase", hi, 8 * T_VCO);
    meas(0, per, hi);
    chk(per == 2 * 2 * T_VCO, "R6", "new ratio after boundary", per, 2 * 2 * T_VCO);

    // R8 sync pulse on q_d, directed and random
    for (int it = 0; it < 6; it++) begin
      int rmin, rmax, ra, rb, rc;
      pre = 1'($urandom % 2);
      sa = $urandom % 4; sb = $urandom % 4; sc = $urandom % 4;
      if (it == 0) begin pre = 0; sa = 0; sb = 2; sc = 1; end
      if (it == 1) begin pre = 1; sa = 3; sb = 1; sc = 2; end
      if (it == 2) begin pre = 0; sa = 2; sb = 2; sc = 2; end
      ra = int'(b_ratio(sa)); rb = int'(b_ratio(sb)); rc = int'(b_ratio(sc));
      rmin = ra; rmax = ra;
      if (rb < rmin) rmin = rb; if (rc < rmin) rmin = rc;
      if (rb > rmax) rmax = rb; if (rc > rmax) rmax = rc;
      start(pre, sa, sb, sc, 0, 0, 0, 0);
      bad = 0; ex = 0; per = 0;
      for (int e = 0; e < 300; e++) begin
        @(posedge clk_vco); #1000;
        if (q_d[0] != q_d[1] || q_d[0] != sync_exp(e, pre ? 4 : 2, rmin, rmax)) begin
          if (bad == 0) begin per = longint'(q_d); ex = sync_exp(e, pre ? 4 : 2, rmin, rmax) ? 3 : 0; end
          bad++;
        end
      end
      chk(bad == 0, "R8", "sync pulse pattern (first mismatch)", per, ex);
    end

    // R9 R10 bypass with each reference
    start(0, 1, 0, 0, 0, 1, 0, 1);
    meas(0, per, hi); ex = 4 * 2 * T_DIF;
    chk(per == ex, "R9", "bypass differential ref period", per, ex);
    chk(hi == ex / 2, "R10", "bypass high time", hi, ex / 2);
    start(1, 2, 0, 0, 2, 1, 1, 1);
    meas(0, per, hi); tsrc = T_SE; ex = 6 * 4 * tsrc;
    chk(per == ex, "R9", "bypass single-ended ref period", per, ex);
    meas(3, per, hi); ex = 32 * 4 * tsrc;
    chk(per == ex, "R10", "bypass feedback period", per, ex);

    // R10 static hold with reference stopped
    ref_run = 1'b0;
    #40000;
    sa = int'({q_d, qv});
    #600000;
    chk(int'({q_d, qv}) == sa, "R10", "outputs hold with ref stopped", longint'({q_d, qv}), sa);
    ref_run = 1'b1;
    meas(0, per, hi); ex = 6 * 4 * T_SE;
    chk(per == ex, "R10", "division resumes after restart", per, ex);

    finish_run();
  end
endmodule